// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the scan timing for a TFT panel. It derives a pixel-rate tick from the core clock, using either a programmable even divide or a straight pass-through. On each tick it advances a pixel counter and a line counter. Every line passes through a sync pulse, a back porch, the visible pixels and a front porch, in that order. Frames follow the same order, counted in lines. From these counters it drives a line sync, a frame sync, a data-enable strobe and a mode line that toggles at a programmable frame interval.

Software loads the timing fields through a plain write port: a strobe, an address and a data word. Writes go to a staging copy. The live copy used by the counters is refreshed only while the block is stopped or at the first pixel of a new frame, so a frame in progress never sees a mix of old and new values. When the run input is low, the counters are held at zero and every output rests at its inactive level.

Top module: `raster_timing_gen`

## Requirements
- R1: With bypass clear and divider field N, the pixel tick `pix_tick_o` is high for one core cycle out of every 2*(N+1). It keeps running through blanking, and the first tick after `run_i` rises comes 2*N+1 cycles later.
- R2: With bypass set, `pix_tick_o` is high on every core cycle while running.
- R3: A line is (HS+1) sync pixels, then (HB+1) back-porch pixels, then (HA+1) active pixels, then (HF+1) front-porch pixels. HS, HB, HF and HA are the written field values. `line_sync_o` is active during the sync pixels only.
- R4: A frame is (VS+1) sync lines, then VB back-porch lines, then (VA+1) active lines, then VF front-porch lines. VB and VF are raw counts and may be zero. `frame_sync_o` is active during the sync lines.
- R5: `data_en_o` is high exactly when the pixel lies in the active pixels of an active line.
- R6: With the line-invert bit clear, `line_sync_o` is active-high; with it set, the output is inverted. The frame-invert bit does the same for `frame_sync_o`.
- R7: With mode field M, `mode_o` starts low at run and toggles at the start of every (M+1)-th frame. M=0 toggles it every frame.
- R8: Writes land in a staging copy that becomes live at the start of the next frame, or continuously while stopped. The register map is as follows. Address 0: divider [7:0], bypass [8], line invert [9], frame invert [10]. Address 1: HS [7:0], HB [15:8], HF [23:16]. Address 2: VS [7:0], VB [15:8], VF [23:16]. Address 3: HA [10:0], VA [25:16]. Address 4: M [7:0]. All fields reset to zero.
- R9: While `run_i` is low, and after reset, `data_en_o` and `pix_tick_o` are low, `mode_o` is low and both syncs sit at their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run enable; low holds the counters at zero |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| pix_tick_o | output | 1 | One-core-cycle pixel-rate tick |
| line_sync_o | output | 1 | Line sync, polarity per line-invert bit |
| frame_sync_o | output | 1 | Frame sync, polarity per frame-invert bit |
| data_en_o | output | 1 | Active-pixel strobe |
| mode_o | output | 1 | Frame-interval mode toggle |

## Verification
All outputs are combinational decodes of registered counters, so each result is due in the same core cycle as the counter state it reflects. The counters move only at the clock edge that ends a cycle with `pix_tick_o` high. The bench samples one time unit after each falling edge and keeps its own pixel, line, tick-phase and frame model in step with that timing. A write becomes staged at the next rising edge and goes live at the edge that ends the last pixel of the frame. The bench therefore switches its expected timing at that same frame boundary, and after a stop it waits two cycles before checking the idle levels. The sweep runs every bypass and divider setting from 0 to 3, porches of zero, both polarities, several mode intervals and a rewrite in the middle of a frame.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    localparam int DIV_W = 8;   // pixel clock divider field
    localparam int HP_W  = 8;   // horizontal sync/porch fields
    localparam int VP_W  = 8;   // vertical sync/porch fields
    localparam int HA_W  = 11;  // active width field (up to 2048)
    localparam int VA_W  = 10;  // active height field (up to 1024)
    localparam int MV_W  = 8;   // mode interval field

    localparam int HC_W = HA_W + 2;
    localparam int VC_W = VA_W + 2;

    localparam logic [2:0] ADDR_CLK  = 3'd0;
    localparam logic [2:0] ADDR_HOR  = 3'd1;
    localparam logic [2:0] ADDR_VER  = 3'd2;
    localparam logic [2:0] ADDR_SIZE = 3'd3;
    localparam logic [2:0] ADDR_MODE = 3'd4;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             bypass;
        logic             inv_line;
        logic             inv_frame;
        logic [HP_W-1:0]  hsw;
        logic [HP_W-1:0]  hbp;
        logic [HP_W-1:0]  hfp;
        logic [VP_W-1:0]  vsw;
        logic [VP_W-1:0]  vbp;
        logic [VP_W-1:0]  vfp;
        logic [HA_W-1:0]  hact;
        logic [VA_W-1:0]  vact;
        logic [MV_W-1:0]  mval;
    } cfg_t;

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              load_i,
    output cfg_t              live_o
);

    typedef struct packed {
        cfg_t stage;
        cfg_t live;
    } regs_t;

    regs_t st_d, st_q;

    logic unused_bits;
    assign unused_bits = ^wr_data_i[DATA_W-1:26];

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            case (wr_addr_i)
                ADDR_CLK: begin
                    st_d.stage.div       = wr_data_i[DIV_W-1:0];
                    st_d.stage.bypass    = wr_data_i[8];
                    st_d.stage.inv_line  = wr_data_i[9];
                    st_d.stage.inv_frame = wr_data_i[10];
                end
                ADDR_HOR: begin
                    st_d.stage.hsw = wr_data_i[0  +: HP_W];
                    st_d.stage.hbp = wr_data_i[8  +: HP_W];
                    st_d.stage.hfp = wr_data_i[16 +: HP_W];
                end
                ADDR_VER: begin
                    st_d.stage.vsw = wr_data_i[0  +: VP_W];
                    st_d.stage.vbp = wr_data_i[8  +: VP_W];
                    st_d.stage.vfp = wr_data_i[16 +: VP_W];
                end
                ADDR_SIZE: begin
                    st_d.stage.hact = wr_data_i[0  +: HA_W];
                    st_d.stage.vact = wr_data_i[16 +: VA_W];
                end
                ADDR_MODE: begin
                    st_d.stage.mval = wr_data_i[0 +: MV_W];
                end
                default: ;
            endcase
        end
        // live copy takes the value staged before this edge
        if (load_i) begin
            st_d.live = st_q.stage;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign live_o = st_q.live;

    AST_LIVE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(live_o)); // R8

endmodule

// File: rtl/rtg_clkdiv.sv
module rtg_clkdiv
    import rtg_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             bypass_i,
    output logic             tick_o
);

    localparam int CW = DIV_W + 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        // divide by 2*(div+1): terminal count is 2*div+1
        limit  = bypass_i ? '0 : {div_i, 1'b1};
        tick_o = run_i && (cnt_q >= limit);
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_BYPASS_EVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && bypass_i) |-> tick_o); // R2

    AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && tick_o && !bypass_i) |=> (!tick_o || bypass_i)); // R1

endmodule

// File: rtl/rtg_scan.sv
module rtg_scan
    import rtg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic tick_i,
    input  cfg_t cfg_i,
    output logic line_sync_o,
    output logic frame_sync_o,
    output logic data_en_o,
    output logic mode_o,
    output logic wrap_o
);

    typedef struct packed {
        logic [HC_W-1:0] h;
        logic [VC_W-1:0] v;
        logic [MV_W-1:0] fcnt;
        logic            mode;
    } scan_t;

    scan_t sc_d, sc_q;

    logic [HC_W-1:0] hs_len, hde_s, hde_e, htot;
    logic [VC_W-1:0] vs_len, vde_s, vde_e, vtot;
    logic            h_last, v_last;
    logic            hs_raw, vs_raw;

    logic unused_cfg;
    assign unused_cfg = ^{cfg_i.div, cfg_i.bypass};

    always_comb begin
        // horizontal: every field stored as count-1
        hs_len = HC_W'(cfg_i.hsw) + HC_W'(1);
        hde_s  = HC_W'(cfg_i.hsw) + HC_W'(cfg_i.hbp) + HC_W'(2);
        hde_e  = hde_s + HC_W'(cfg_i.hact) + HC_W'(1);
        htot   = hde_e + HC_W'(cfg_i.hfp) + HC_W'(1);
        // vertical: sync and size count-1, porches raw
        vs_len = VC_W'(cfg_i.vsw) + VC_W'(1);
        vde_s  = vs_len + VC_W'(cfg_i.vbp);
        vde_e  = vde_s + VC_W'(cfg_i.vact) + VC_W'(1);
        vtot   = vde_e + VC_W'(cfg_i.vfp);

        h_last = (sc_q.h == htot - HC_W'(1));
        v_last = (sc_q.v == vtot - VC_W'(1));
        wrap_o = run_i && tick_i && h_last && v_last;

        sc_d = sc_q;
        if (!run_i) begin
            sc_d = '0;
        end else if (tick_i) begin
            if (h_last) begin
                sc_d.h = '0;
                if (v_last) begin
                    sc_d.v = '0;
                    if (sc_q.fcnt == cfg_i.mval) begin
                        sc_d.fcnt = '0;
                        sc_d.mode = !sc_q.mode;
                    end else begin
                        sc_d.fcnt = sc_q.fcnt + MV_W'(1);
                    end
                end else begin
                    sc_d.v = sc_q.v + VC_W'(1);
                end
            end else begin
                sc_d.h = sc_q.h + HC_W'(1);
            end
        end

        hs_raw       = run_i && (sc_q.h < hs_len);
        vs_raw       = run_i && (sc_q.v < vs_len);
        line_sync_o  = hs_raw ^ cfg_i.inv_line;
        frame_sync_o = vs_raw ^ cfg_i.inv_frame;
        data_en_o    = run_i && (sc_q.h >= hde_s) && (sc_q.h < hde_e)
                             && (sc_q.v >= vde_s) && (sc_q.v < vde_e);
        mode_o       = sc_q.mode;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sc_q <= '0;
        end else begin
            sc_q <= sc_d;
        end
    end

    AST_H_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (sc_q.h < htot)); // R3

    AST_V_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (sc_q.v < vtot)); // R4

    AST_MOVE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !tick_i) |=> ($stable(sc_q.h) && $stable(sc_q.v))); // R1

    AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        data_en_o |-> (!hs_raw && !vs_raw)); // R5

    AST_IDLE_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |-> (!data_en_o && (line_sync_o == cfg_i.inv_line)
                    && (frame_sync_o == cfg_i.inv_frame))); // R9

    AST_MODE_AT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !wrap_o) |=> (sc_q.mode == $past(sc_q.mode))); // R7

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              pix_tick_o,
    output logic              line_sync_o,
    output logic              frame_sync_o,
    output logic              data_en_o,
    output logic              mode_o
);

    cfg_t live;
    logic wrap;
    logic load;

    assign load = !run_i || wrap;

    rtg_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .load_i    (load),
        .live_o    (live)
    );

    rtg_clkdiv u_clkdiv (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (run_i),
        .div_i    (live.div),
        .bypass_i (live.bypass),
        .tick_o   (pix_tick_o)
    );

    rtg_scan u_scan (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .run_i        (run_i),
        .tick_i       (pix_tick_o),
        .cfg_i        (live),
        .line_sync_o  (line_sync_o),
        .frame_sync_o (frame_sync_o),
        .data_en_o    (data_en_o),
        .mode_o       (mode_o),
        .wrap_o       (wrap)
    );

    AST_IDLE_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |-> (!pix_tick_o && !data_en_o)); // R9

endmodule

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        int div; int byp; int il; int ifr;
        int hsw; int hbp; int hfp;
        int vsw; int vbp; int vfp;
        int hact; int vact; int mval;
    } bcfg_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pix_tick, line_sync, frame_sync, data_en, mode;

    int checks = 0;
    int errors = 0;

    bcfg_t pend, act;
    int h = 0, v = 0, ncyc = 0, frames = 0, fcnt = 0, mode_m = 0;
    bit shadow_phase = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    raster_timing_gen u_raster_timing_gen (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .run_i        (run),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .pix_tick_o   (pix_tick),
        .line_sync_o  (line_sync),
        .frame_sync_o (frame_sync),
        .data_en_o    (data_en),
        .mode_o       (mode)
    );

    task automatic chk(string req, string what, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    // check the current cycle one unit after the falling edge, advance the model
    task automatic step();
        #1;
        if (run) begin
            int period, hs_len, hde_s, hde_e, htot, vs_len, vde_s, vde_e, vtot;
            int e_tick, e_hs, e_vs, e_de;
            period = (act.byp != 0) ? 1 : 2 * (act.div + 1);
            hs_len = act.hsw + 1;
            hde_s  = act.hsw + act.hbp + 2;
            hde_e  = hde_s + act.hact + 1;
            htot   = hde_e + act.hfp + 1;
            vs_len = act.vsw + 1;
            vde_s  = vs_len + act.vbp;
            vde_e  = vde_s + act.vact + 1;
            vtot   = vde_e + act.vfp;
            e_tick = (ncyc == period - 1) ? 1 : 0;
            e_hs   = ((h < hs_len) ? 1 : 0) ^ act.il;
            e_vs   = ((v < vs_len) ? 1 : 0) ^ act.ifr;
            e_de   = (h >= hde_s && h < hde_e && v >= vde_s && v < vde_e) ? 1 : 0;
            chk((act.byp != 0) ? "R2" : "R1", "pix_tick", int'(pix_tick), e_tick);
            chk(shadow_phase ? "R8" : ((act.il != 0) ? "R6" : "R3"),
                "line_sync", int'(line_sync), e_hs);
            chk((act.ifr != 0) ? "R6" : "R4", "frame_sync", int'(frame_sync), e_vs);
            chk("R5", "data_en", int'(data_en), e_de);
            chk("R7", "mode", int'(mode), mode_m);
            if (e_tick != 0) begin
                ncyc = 0;
                if (h == htot - 1) begin
                    h = 0;
                    if (v == vtot - 1) begin
                        v = 0;
                        frames++;
                        if (fcnt == act.mval) begin
                            fcnt = 0;
                            mode_m = 1 - mode_m;
                        end else begin
                            fcnt++;
                        end
                        act = pend;
                    end else begin
                        v++;
                    end
                end else begin
                    h++;
                end
            end else begin
                ncyc++;
            end
        end else begin
            h = 0; v = 0; ncyc = 0; fcnt = 0; mode_m = 0;
            act = pend;
        end
        @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        step();
        case (a)
            3'd0: begin pend.div = int'(d[7:0]); pend.byp = int'(d[8]);
                        pend.il = int'(d[9]); pend.ifr = int'(d[10]); end
            3'd1: begin pend.hsw = int'(d[7:0]); pend.hbp = int'(d[15:8]);
                        pend.hfp = int'(d[23:16]); end
            3'd2: begin pend.vsw = int'(d[7:0]); pend.vbp = int'(d[15:8]);
                        pend.vfp = int'(d[23:16]); end
            3'd3: begin pend.hact = int'(d[10:0]); pend.vact = int'(d[25:16]); end
            3'd4: pend.mval = int'(d[7:0]);
            default: ;
        endcase
        wr_en = 1'b0;
    endtask

    task automatic load_cfg(bcfg_t c);
        wr(3'd0, 32'(c.div | (c.byp << 8) | (c.il << 9) | (c.ifr << 10)));
        wr(3'd1, 32'(c.hsw | (c.hbp << 8) | (c.hfp << 16)));
        wr(3'd2, 32'(c.vsw | (c.vbp << 8) | (c.vfp << 16)));
        wr(3'd3, 32'(c.hact | (c.vact << 16)));
        wr(3'd4, 32'(c.mval));
    endtask

    task automatic start();
        step();
        step();
        run = 1'b1;
    endtask

    task automatic run_frames(int n);
        int target = frames + n;
        while (frames < target) step();
    endtask

    task automatic stop_and_check(int il, int ifr);
        run = 1'b0;
        step();
        step();
        #1;
        chk("R9", "idle pix_tick", int'(pix_tick), 0);
        chk("R9", "idle data_en", int'(data_en), 0);
        chk("R9", "idle mode", int'(mode), 0);
        chk((il != 0) ? "R6" : "R9", "idle line_sync", int'(line_sync), il);
        chk((ifr != 0) ? "R6" : "R9", "idle frame_sync", int'(frame_sync), ifr);
        @(negedge clk);
    endtask

    initial begin
        bcfg_t ca, cb, cc;
        pend = '{default: 0};
        act  = pend;
        ca = '{div: 0, byp: 0, il: 0, ifr: 0, hsw: 0, hbp: 1, hfp: 0,
               vsw: 1, vbp: 1, vfp: 1, hact: 3, vact: 2, mval: 1};
        cb = '{div: 5, byp: 1, il: 1, ifr: 1, hsw: 0, hbp: 0, hfp: 0,
               vsw: 0, vbp: 0, vfp: 0, hact: 1, vact: 1, mval: 0};
        cc = '{div: 1, byp: 0, il: 0, ifr: 1, hsw: 2, hbp: 0, hfp: 1,
               vsw: 0, vbp: 2, vfp: 0, hact: 2, vact: 0, mval: 2};

        repeat (4) @(negedge clk);
        // reset state, R9
        #1;
        chk("R9", "reset pix_tick", int'(pix_tick), 0);
        chk("R9", "reset line_sync", int'(line_sync), 0);
        chk("R9", "reset frame_sync", int'(frame_sync), 0);
        chk("R9", "reset data_en", int'(data_en), 0);
        chk("R9", "reset mode", int'(mode), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step();

        // divider sweep, R1 and R2
        for (int byp = 0; byp < 2; byp++) begin
            for (int dv = 0; dv < 4; dv++) begin
                if (byp == 1 && dv > 0) break;
                ca.div = dv;
                ca.byp = byp;
                load_cfg(ca);
                start();
                run_frames(3);
                stop_and_check(0, 0);
            end
        end

        // inverted syncs, zero vertical porches, mode every frame: R4 R6 R7
        load_cfg(cb);
        start();
        run_frames(3);
        stop_and_check(1, 1);

        // longer mode interval: R7
        load_cfg(cc);
        start();
        run_frames(7);
        stop_and_check(0, 1);

        // mid-frame rewrite takes effect at the next frame: R8
        ca.div = 0;
        ca.byp = 0;
        load_cfg(ca);
        start();
        repeat (37) step();
        shadow_phase = 1;
        wr(3'd1, 32'h0001_0002);
        wr(3'd3, 32'h0000_0005);
        wr(3'd0, 32'h0000_0201);
        run_frames(1);
        shadow_phase = 0;
        run_frames(2);
        stop_and_check(1, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", frames, -1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule